// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O controller. Software reaches it over a simple word-wide register bus. Each pin is set as an input or an output. An output pin drives the value held in the data register. An input pin passes through a two-stage synchronizer and is then held in a pad-status register.

Every input pin is watched for a condition chosen by a 2-bit mode. The mode selects either the active level (low or high) or the edge (rising or falling). A separate any-edge select bit can override that mode for its pin. A pin that meets its condition sets its bit in a sticky status register. Software clears status bits by writing 1 to them. A level condition that is still present sets its bit again in the same cycle. The status bits are ANDed with a mask to form the interrupt request. A parameter chooses between one request line and two lines, one for the lower pin half and one for the upper pin half. A second parameter removes the any-edge register.

The bus is a combinational read port and a write port. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Only word-aligned addresses are decoded.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is held, every register reads 0, `pin_o` and `pin_oe_o` are 0, and `irq_o` is 0. This covers data, direction, pad status, both configuration registers, mask, status and any-edge.
- R2: The register word offsets are data 0x00, direction 0x04, pad status 0x08, configuration-low 0x0C, configuration-high 0x10, mask 0x14, status 0x18 and any-edge 0x1C. Direction bit 1 makes the pin an output. `pin_oe_o` equals the direction register and `pin_o` equals the data register, both from the edge of the write.
- R3: A data read returns the data bit for each output pin and the pad-status bit for each input pin. A pad-status read returns the sampled level for input pins and 0 for output pins.
- R4: Pin n takes its mode from bits 2n+1:2n of {configuration-high, configuration-low}. Mode 00 sets status while the pad-status level is low. Mode 01 sets status while it is high.
- R5: Mode 10 sets status on a rising edge. Mode 11 sets status on a falling edge. The opposite edge and a steady level set nothing.
- R6: When a pin's any-edge bit is 1, every change of that pin's level sets its status bit, and its 2-bit mode has no effect.
- R7: Status bits are sticky. A status write clears every bit written as 1. A level condition that is still active keeps its bit set through the clear.
- R8: Pins whose direction bit is 1 never set status.
- R9: With the split parameter set, `irq_o[0]` is high when (status AND mask) has any bit in 15:0 set, and `irq_o[1]` is high when it has any bit in 31:16 set. Without the split, `irq_o[0]` covers all 32 bits and `irq_o[1]` is 0.
- R10: When the any-edge register is left out by parameter, it reads 0, writes to it are ignored, and the 2-bit modes alone govern detection.
- R11: Word offsets 0x20 and above, and addresses whose two low bits are not 00, read 0 and ignore writes.
- R12: An input change that is stable before clock edge k appears in pad status after edge k+2 and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_i | input | 32 | External pin levels (asynchronous) |
| pin_o | output | 32 | Output pin levels |
| pin_oe_o | output | 32 | Output enable per pin |
| irq_o | output | 2 | Interrupt request lines |

## Verification
The detection logic is driven first with directed pin patterns. These set single pins to rising, falling, level-high and any-edge modes, and each pattern has a mode under which it must stay silent. That separates a decode of the wrong edge from a decode of the wrong mode bit. Clears are made while a level condition is still active, and again after it has gone, which tells the re-arm behaviour apart from a plain clear. The bench then runs long stretches of random pin vectors mixed with random writes to every register, including the unmapped offsets. These are compared against a bench model of the per-pin rules, which catches interactions between direction, mode and any-edge that the directed cases miss. A second instance, built without the any-edge register and without the split, shows that the any-edge write has no effect and that the single request line merges both halves.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    // Word indices (byte address >> 2) of the registers
    localparam int OFS_DATA  = 0;
    localparam int OFS_DIR   = 1;
    localparam int OFS_PAD   = 2;
    localparam int OFS_CFGL  = 3;
    localparam int OFS_CFGH  = 4;
    localparam int OFS_MASK  = 5;
    localparam int OFS_STAT  = 6;
    localparam int OFS_AEDGE = 7;

    // Per-pin detection mode: edge_md selects edge vs level, pol the active level / edge
    typedef struct packed {
        logic edge_md;
        logic pol;
    } pin_mode_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
    import gpio_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic [NPIN-1:0]   lvl_now,   // synchronized level, one cycle ahead of pad status
    input  logic [NPIN-1:0]   lvl_prev,  // pad status register
    input  logic [NPIN-1:0]   is_input,
    input  logic [NPIN-1:0]   any_edge,
    input  logic [2*NPIN-1:0] cfg,
    output logic [NPIN-1:0]   hit
);
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        pin_mode_t md;
        logic      chg;
        assign md  = pin_mode_t'(cfg[2*g+1 -: 2]);
        assign chg = lvl_now[g] ^ lvl_prev[g];

        always_comb begin
            if (!is_input[g]) begin
                hit[g] = 1'b0;
            end else if (any_edge[g]) begin
                hit[g] = chg;
            end else if (md.edge_md) begin
                hit[g] = chg & (lvl_now[g] != md.pol);
            end else begin
                hit[g] = (lvl_prev[g] == md.pol);
            end
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int NPIN         = 32,
    parameter int ADDR_W       = 6,
    parameter int SYNC_STAGES  = 2,
    parameter bit HAS_ANY_EDGE = 1'b1,
    parameter bit SPLIT_IRQ    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pin_i,
    output logic [NPIN-1:0]   pin_o,
    output logic [NPIN-1:0]   pin_oe_o,
    output logic [1:0]        irq_o
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int HALF   = NPIN / 2;

    logic [NPIN-1:0]   data_q, dir_q, pad_q, mask_q, stat_q, aedge_q;
    logic [2*NPIN-1:0] cfg_q;
    logic [NPIN-1:0]   sync_lvl, hit, pend;
    logic [WORD_W-1:0] word;
    logic              acc_ok, wr_ok;
    logic              we_data, we_dir, we_cfgl, we_cfgh, we_mask, we_stat, we_aedge;

    assign word   = bus_addr[ADDR_W-1:2];
    assign acc_ok = bus_sel && (bus_addr[1:0] == 2'b00);
    assign wr_ok  = acc_ok && bus_wr;

    assign we_data  = wr_ok && (word == WORD_W'(OFS_DATA));
    assign we_dir   = wr_ok && (word == WORD_W'(OFS_DIR));
    assign we_cfgl  = wr_ok && (word == WORD_W'(OFS_CFGL));
    assign we_cfgh  = wr_ok && (word == WORD_W'(OFS_CFGH));
    assign we_mask  = wr_ok && (word == WORD_W'(OFS_MASK));
    assign we_stat  = wr_ok && (word == WORD_W'(OFS_STAT));
    assign we_aedge = wr_ok && (word == WORD_W'(OFS_AEDGE));

    gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (sync_lvl)
    );

    gpio_detect #(.NPIN(NPIN)) u_detect (
        .lvl_now  (sync_lvl),
        .lvl_prev (pad_q),
        .is_input (~dir_q),
        .any_edge (aedge_q),
        .cfg      (cfg_q),
        .hit      (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            pad_q  <= '0;
            cfg_q  <= '0;
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            pad_q <= sync_lvl;
            if (we_data) data_q <= bus_wdata;
            if (we_dir)  dir_q  <= bus_wdata;
            if (we_cfgl) cfg_q[NPIN-1:0]      <= bus_wdata;
            if (we_cfgh) cfg_q[2*NPIN-1:NPIN] <= bus_wdata;
            if (we_mask) mask_q <= bus_wdata;
            stat_q <= (stat_q & ~(we_stat ? bus_wdata : '0)) | hit;
        end
    end

    if (HAS_ANY_EDGE) begin : g_aedge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        aedge_q <= '0;
            else if (we_aedge) aedge_q <= bus_wdata;
        end
    end else begin : g_no_aedge
        assign aedge_q = '0;
    end

    always_comb begin
        bus_rdata = '0;
        if (acc_ok) begin
            case (word)
                WORD_W'(OFS_DATA):  bus_rdata = (data_q & dir_q) | (pad_q & ~dir_q);
                WORD_W'(OFS_DIR):   bus_rdata = dir_q;
                WORD_W'(OFS_PAD):   bus_rdata = pad_q & ~dir_q;
                WORD_W'(OFS_CFGL):  bus_rdata = cfg_q[NPIN-1:0];
                WORD_W'(OFS_CFGH):  bus_rdata = cfg_q[2*NPIN-1:NPIN];
                WORD_W'(OFS_MASK):  bus_rdata = mask_q;
                WORD_W'(OFS_STAT):  bus_rdata = stat_q;
                WORD_W'(OFS_AEDGE): bus_rdata = aedge_q;
                default:            bus_rdata = '0;
            endcase
        end
    end

    assign pin_o    = data_q;
    assign pin_oe_o = dir_q;
    assign pend     = stat_q & mask_q;

    if (SPLIT_IRQ) begin : g_split
        assign irq_o = {|pend[NPIN-1:HALF], |pend[HALF-1:0]};
        // R9
        upper_line_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[1] |-> (stat_q[NPIN-1:HALF] != '0));
    end else begin : g_single
        assign irq_o = {1'b0, |pend};
    end

    // R8
    out_pin_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q)) & $past(dir_q)) == '0);

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_stat |=> ((stat_q & $past(bus_wdata & ~hit)) == '0));

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_stat |=> (($past(stat_q) & ~stat_q) == '0));

    // R2
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_dir |=> $stable(pin_oe_o));
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0, tgt = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] pin_i = '0;
    logic [31:0] rdata0, rdata1, pin_o0, pin_oe0, pin_o1, pin_oe1;
    logic [1:0]  irq0, irq1;
    int          n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    gpio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel & ~tgt), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata0), .pin_i(pin_i), .pin_o(pin_o0),
        .pin_oe_o(pin_oe0), .irq_o(irq0));

    gpio_irq_ctrl #(.HAS_ANY_EDGE(1'b0), .SPLIT_IRQ(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel & tgt), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata1), .pin_i(pin_i), .pin_o(pin_o1),
        .pin_oe_o(pin_oe1), .irq_o(irq1));

    // Bench model of u0
    logic [31:0] m_dr = '0, m_dir = '0, m_mk = '0, m_ae = '0, m_st = '0, m_lvl = '0;
    logic [63:0] m_cfg = '0;

    function automatic logic [31:0] lvl_set(input logic [31:0] l);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++)
            r[i] = !m_dir[i] && !m_ae[i] && !m_cfg[2*i+1] && (l[i] == m_cfg[2*i]);
        return r;
    endfunction

    function automatic logic [31:0] edge_set(input logic [31:0] o, input logic [31:0] n);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) begin
            if (!m_dir[i] && (o[i] != n[i])) begin
                if (m_ae[i])           r[i] = 1'b1;
                else if (m_cfg[2*i+1]) r[i] = (n[i] != m_cfg[2*i]);
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (a)
            6'h00: return (m_dr & m_dir) | (m_lvl & ~m_dir);
            6'h04: return m_dir;
            6'h08: return m_lvl & ~m_dir;
            6'h0C: return m_cfg[31:0];
            6'h10: return m_cfg[63:32];
            6'h14: return m_mk;
            6'h18: return m_st;
            6'h1C: return m_ae;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        case (a)
            6'h00, 6'h08: return "R3";
            6'h04: return "R2";
            6'h0C, 6'h10: return "R4";
            6'h14: return "R9";
            6'h18: return "R7";
            6'h1C: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic t, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        tgt = t; sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic t, input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        tgt = t; sel = 1'b1; wr = 1'b0; addr = a;
        #1 v = t ? rdata1 : rdata0;
        sel = 1'b0;
    endtask

    // write to u0 and update the model
    task automatic wr0(input logic [5:0] a, input logic [31:0] d);
        bus_write(1'b0, a, d);
        case (a)
            6'h00: m_dr = d;
            6'h04: m_dir = d;
            6'h0C: m_cfg[31:0] = d;
            6'h10: m_cfg[63:32] = d;
            6'h14: m_mk = d;
            6'h18: m_st = m_st & ~d;
            6'h1C: m_ae = d;
            default: ;
        endcase
        m_st = m_st | lvl_set(m_lvl);
        repeat (2) @(posedge clk);
    endtask

    task automatic pins(input logic [31:0] n);
        @(negedge clk);
        pin_i = n;
        repeat (4) @(posedge clk);
        m_st = m_st | edge_set(m_lvl, n) | lvl_set(n);
        m_lvl = n;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(1'b0, a, v);
        chk(tag, v, exp);
    endtask

    task automatic check_all();
        logic [31:0] v, p;
        for (int w = 0; w < 10; w++) begin
            bus_read(1'b0, 6'(w * 4), v);
            chk(tag_of(6'(w * 4)), v, exp_read(6'(w * 4)));
        end
        #1;
        chk("R2 pin_o", pin_o0, m_dr);
        chk("R2 pin_oe", pin_oe0, m_dir);
        p = m_st & m_mk;
        chk("R9 irq", {30'd0, irq0}, {30'd0, |p[31:16], |p[15:0]});
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd20240611));

        // R1 reset state, checked while reset is held
        repeat (3) @(posedge clk);
        for (int w = 0; w < 8; w++) begin
            bus_read(1'b0, 6'(w * 4), v);
            chk("R1 reg", v, 32'h0);
        end
        chk("R1 pin_o", pin_o0, 32'h0);
        chk("R1 pin_oe", pin_oe0, 32'h0);
        chk("R1 irq", {30'd0, irq0}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        m_st = lvl_set(m_lvl);
        repeat (3) @(posedge clk);
        rd_chk("R4 default level-low", 6'h18, 32'hFFFF_FFFF);

        // all pins rising-edge mode, then clear status
        wr0(6'h0C, 32'hAAAA_AAAA);
        wr0(6'h10, 32'hAAAA_AAAA);
        wr0(6'h18, 32'hFFFF_FFFF);
        rd_chk("R7 clear", 6'h18, 32'h0);

        // R12 synchronizer latency
        @(negedge clk) pin_i = 32'h1;
        @(posedge clk); @(posedge clk);
        rd_chk("R12 not yet", 6'h08, 32'h0);
        @(posedge clk);
        rd_chk("R12 arrived", 6'h08, 32'h1);
        rd_chk("R5 rising", 6'h18, 32'h1);
        m_lvl = 32'h1; m_st = 32'h1;
        repeat (2) @(posedge clk);

        wr0(6'h18, 32'h1);
        pins(32'h0);
        rd_chk("R5 falling ignored in rising mode", 6'h18, 32'h0);
        wr0(6'h0C, 32'hAAAA_AAAB);
        pins(32'h1);
        rd_chk("R5 rising ignored in falling mode", 6'h18, 32'h0);
        pins(32'h0);
        rd_chk("R5 falling", 6'h18, 32'h1);

        // R4 level-high on pin 2, re-arm on clear
        wr0(6'h18, 32'hFFFF_FFFF);
        wr0(6'h0C, 32'hAAAA_AA9B);
        rd_chk("R4 level inactive", 6'h18, 32'h0);
        pins(32'h4);
        rd_chk("R4 level high", 6'h18, 32'h4);
        wr0(6'h18, 32'h4);
        rd_chk("R7 re-arm", 6'h18, 32'h4);
        pins(32'h0);
        wr0(6'h18, 32'h4);
        rd_chk("R7 clear after level gone", 6'h18, 32'h0);

        // R6 any-edge on pin 3 overrides level-high mode
        wr0(6'h0C, 32'hAAAA_AA5B);
        wr0(6'h1C, 32'h8);
        pins(32'h8);
        rd_chk("R6 any-edge rise", 6'h18, 32'h8);
        wr0(6'h18, 32'h8);
        rd_chk("R6 level mode overridden", 6'h18, 32'h0);
        pins(32'h0);
        rd_chk("R6 any-edge fall", 6'h18, 32'h8);

        // R8 / R2 / R3 output pin
        wr0(6'h18, 32'hFFFF_FFFF);
        wr0(6'h04, 32'h10);
        wr0(6'h00, 32'h30);
        chk("R2 pin_oe", pin_oe0, 32'h10);
        chk("R2 pin_o", pin_o0, 32'h30);
        pins(32'h10);
        rd_chk("R8 output pin no status", 6'h18, 32'h0);
        rd_chk("R3 data mix", 6'h00, 32'h10);
        rd_chk("R3 pad masks outputs", 6'h08, 32'h0);

        // R11 unmapped and misaligned
        wr0(6'h20, 32'hFFFF_FFFF);
        bus_write(1'b0, 6'h01, 32'h0);
        bus_write(1'b0, 6'h05, 32'h0);
        rd_chk("R11 unmapped read", 6'h20, 32'h0);
        rd_chk("R11 misaligned read", 6'h04 | 6'h2, 32'h0);
        rd_chk("R11 data kept", 6'h00, 32'h10);
        rd_chk("R11 dir kept", 6'h04, 32'h10);

        // R9 split lines
        wr0(6'h18, 32'hFFFF_FFFF);
        wr0(6'h04, 32'h0);
        pins(32'h0001_0001);
        rd_chk("R5 pin16 rising", 6'h18, 32'h0001_0000);
        wr0(6'h14, 32'h0000_FFFF);
        chk("R9 lower only", {30'd0, irq0}, 32'h0);
        wr0(6'h14, 32'hFFFF_0000);
        chk("R9 upper line", {30'd0, irq0}, 32'h2);
        check_all();

        // random stimulus
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0: pins($urandom);
                1: pins(m_lvl ^ (32'h1 << $urandom_range(0, 31)));
                2: wr0(6'($urandom_range(0, 9) * 4), $urandom);
                3: wr0(6'h18, $urandom);
                default: wr0(6'($urandom_range(0, 7) * 4), $urandom);
            endcase
            check_all();
        end

        // R10 / R9 on the reduced instance
        pins(32'h0000_FFFF);
        bus_write(1'b1, 6'h1C, 32'hFFFF_FFFF);
        bus_read(1'b1, 6'h1C, v);
        chk("R10 any-edge reads 0", v, 32'h0);
        bus_write(1'b1, 6'h18, 32'hFFFF_FFFF);
        repeat (2) @(posedge clk);
        bus_read(1'b1, 6'h18, v);
        chk("R10 write ignored, level-low re-arms", v, 32'hFFFF_0000);
        bus_write(1'b1, 6'h14, 32'h0001_0000);
        #1 chk("R9 single line upper bit", {30'd0, irq1}, 32'h1);
        bus_write(1'b1, 6'h14, 32'h0000_FFFF);
        #1 chk("R9 single line masked", {30'd0, irq1}, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule